// File: doc/BRIEF.md
# Clock-Domain Shutdown and Restart Sequencer

This controller sits in an always-on clock domain next to a register crossing that links a master clock domain and a slave clock domain. Software asks it to turn one of the two domains off or back on. The controller then steps that domain's bypass, reset and clock-enable outputs through a fixed order. While the domain is being taken down, it also waits on the crossing's in-flight flag, so that no transaction is cut off partway through.

Turning the slave domain off has three steps. The controller first diverts master requests into bypass, so that they complete as no-ops. It then waits for the single in-flight transaction to drain, asserts the slave reset, and finally stops the slave clock if asked to. Turning the slave domain back on runs the steps in reverse order. The clock runs for a programmable settling time before reset is released, and bypass is dropped last. The master domain follows the same path without the bypass step. Power is never removed.

Each request carries a clock-gating choice. The block reports busy and a one-cycle done pulse. It flags an illegal domain code with a one-cycle error pulse. If the drain wait runs past a programmable limit, it raises a sticky timeout flag and holds in the wait until software aborts.

Top module: `domain_power_sequencer`

## Requirements
- R1: After reset, both clock enables are 1, both resets are 0, slave bypass is 0, and busy, done, err_illegal and err_timeout are all 0.
- R2: When a slave-off request (req_dom=1, req_on=0) is accepted at an edge, slv_bypass rises at that same edge, while slv_reset is still 0.
- R3: During an off sequence, the domain's reset rises at the first edge after acceptance at which xing_busy is sampled low. While xing_busy stays high, the reset stays 0.
- R4: One edge after the reset rises, the domain's clock enable drops only if req_gate was 1 when the request was accepted. At that same edge, done pulses high for one cycle and busy drops.
- R5: A master-off request (req_dom=0, req_on=0) follows the same drain, reset and gate timing and never changes slv_bypass.
- R6: When an on request is accepted at edge E0, the clock enable is 1 from E0. The domain's reset falls at edge E0+max(cfg_settle,1). One edge after that, slv_bypass falls (slave only) and done pulses.
- R7: slv_reset is never 1 while slv_bypass is 0. slv_bypass never falls while slv_reset is 1.
- R8: A request with req_dom of 2 or 3 is illegal. It gives a one-cycle err_illegal pulse at the next edge, with no done and no change to any domain output.
- R9: A request that arrives while busy is 1 is ignored.
- R10: A request to turn off a domain that is already off, or to turn on a domain that is already on, gives done at the next edge and changes no domain output.
- R11: If xing_busy is still high at the edge where cfg_timeout wait edges have passed, err_timeout becomes 1. It stays 1, and the reset stays 0, even if xing_busy later clears.
- R12: An abort during the drain wait returns the block to idle at the next edge. It clears err_timeout, withdraws slave bypass and does not pulse done. An abort at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_dom | input | 2 | Target domain: 0 master, 1 slave, 2 and 3 illegal |
| req_on | input | 1 | 1 turn on, 0 turn off |
| req_gate | input | 1 | On an off request, also stop the clock |
| abort | input | 1 | Leave the drain wait |
| cfg_settle | input | CNT_W | Clock cycles run before reset release |
| cfg_timeout | input | CNT_W | Drain wait limit in cycles |
| xing_busy | input | 1 | Crossing has a transaction in flight |
| mst_clk_en | output | 1 | Master domain clock enable |
| mst_reset | output | 1 | Master domain reset, active high |
| slv_clk_en | output | 1 | Slave domain clock enable |
| slv_reset | output | 1 | Slave domain reset, active high |
| slv_bypass | output | 1 | Master requests complete as no-ops |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| err_illegal | output | 1 | One-cycle illegal-request pulse |
| err_timeout | output | 1 | Sticky drain timeout flag |

## Verification
Every output is registered, so each result is due a fixed whole number of edges after the accepting edge E0. Bypass and clock restart are due at E0. Reset assertion is due one edge after the last busy-high edge, and clock stop and done one edge after that. Reset release is due at E0+max(settle,1), and bypass release and done one edge later. Timeout is due at E0+cfg_timeout. The bench drives and samples on falling edges and counts these edges explicitly. At each sample it checks both the value just before the due edge and the value just after it, so that a result arriving one cycle early or late is caught.

// File: rtl/dps_pkg.sv
// Shared types for the domain sequencer: step encoding and per-domain commands.
package dps_pkg;

    localparam int DOM_COUNT = 2;
    localparam int DOM_MST   = 0;
    localparam int DOM_SLV   = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_HALT,
        ST_SETTLE,
        ST_RELEASE
    } step_e;

    typedef struct packed {
        logic bypass_on;
        logic bypass_off;
        logic reset_on;
        logic reset_off;
        logic clk_stop;
        logic clk_run;
    } dom_cmd_t;

endpackage

// File: rtl/dps_counter.sv
// Saturating wait counter shared by the settle and drain-timeout waits.
// Assumes the two waits never overlap; limit is muxed by the caller.
// hit is high when the increment at this edge reaches the limit.
module dps_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    // Count increments since the last clear, saturating at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc && !(&cnt_q))
            cnt_q <= cnt_q + W'(1);
    end

    // Compare one ahead so that a limit of zero behaves as a limit of one.
    assign hit = ({1'b0, cnt_q} + (W+1)'(1)) >= {1'b0, limit};

endmodule

// File: rtl/dps_domain.sv
// Output register set for one controlled domain: clock enable, reset, bypass.
// Powers up with the domain running. Commands come as single-cycle strobes.
module dps_domain
    import dps_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  dom_cmd_t cmd,
    output logic     clk_en,
    output logic     dom_reset,
    output logic     bypass
);
    // Clock enable: running at power-on, stopped and restarted on command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clk_en <= 1'b1;
        else if (cmd.clk_run)
            clk_en <= 1'b1;
        else if (cmd.clk_stop)
            clk_en <= 1'b0;
    end

    // Domain reset: released at power-on, raised and lowered on command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dom_reset <= 1'b0;
        else if (cmd.reset_on)
            dom_reset <= 1'b1;
        else if (cmd.reset_off)
            dom_reset <= 1'b0;
    end

    // Bypass: low at power-on, raised and lowered on command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bypass <= 1'b0;
        else if (cmd.bypass_on)
            bypass <= 1'b1;
        else if (cmd.bypass_off)
            bypass <= 1'b0;
    end

endmodule

// File: rtl/dps_fsm.sv
// Step sequencer: accepts requests when idle and issues per-domain command
// strobes in the required order. Assumes dom_off and dom_byp reflect the
// registered domain outputs, and a single shared wait counter.
module dps_fsm
    import dps_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [1:0]                      req_dom,
    input  logic                            req_on,
    input  logic                            req_gate,
    input  logic                            abort,
    input  logic                            xing_busy,
    input  logic                            cnt_hit,
    input  logic [DOM_COUNT-1:0]            dom_off,
    input  logic [DOM_COUNT-1:0]            dom_byp,
    output dom_cmd_t [DOM_COUNT-1:0]        cmd,
    output logic                            cnt_clr,
    output logic                            cnt_inc,
    output logic                            in_settle,
    output logic                            busy,
    output logic                            done,
    output logic                            err_illegal,
    output logic                            err_timeout
);
    step_e state_q, state_d;
    logic  sel_q, gate_q;
    logic  done_d, ill_d, tmo_set, tmo_clr, capture;
    logic  req_idx, already, byp_ok;

    assign req_idx = req_dom[0];
    assign already = req_on ? !dom_off[req_idx] : dom_off[req_idx];
    // Interlock: the slave may only enter reset with bypass held.
    assign byp_ok  = (sel_q != 1'(DOM_SLV)) || dom_byp[DOM_SLV];

    // Next step, command strobes and status events for this cycle.
    always_comb begin
        state_d = state_q;
        cmd     = '0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        done_d  = 1'b0;
        ill_d   = 1'b0;
        tmo_set = 1'b0;
        tmo_clr = 1'b0;
        capture = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_dom[1]) begin
                        ill_d = 1'b1;
                    end else if (already) begin
                        done_d = 1'b1;
                    end else begin
                        capture = 1'b1;
                        cnt_clr = 1'b1;
                        if (req_on) begin
                            cmd[req_idx].clk_run = 1'b1;
                            state_d = ST_SETTLE;
                        end else begin
                            if (req_idx == 1'(DOM_SLV))
                                cmd[DOM_SLV].bypass_on = 1'b1;
                            state_d = ST_DRAIN;
                        end
                    end
                end
            end
            ST_DRAIN: begin
                if (abort) begin
                    cmd[sel_q].bypass_off = 1'b1;
                    tmo_clr = 1'b1;
                    state_d = ST_IDLE;
                end else if (!err_timeout) begin
                    if (!xing_busy && byp_ok) begin
                        cmd[sel_q].reset_on = 1'b1;
                        state_d = ST_HALT;
                    end else begin
                        cnt_inc = 1'b1;
                        tmo_set = cnt_hit;
                    end
                end
            end
            ST_HALT: begin
                cmd[sel_q].clk_stop = gate_q;
                done_d  = 1'b1;
                state_d = ST_IDLE;
            end
            ST_SETTLE: begin
                cnt_inc = 1'b1;
                if (cnt_hit) begin
                    cmd[sel_q].reset_off = 1'b1;
                    state_d = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                cmd[sel_q].bypass_off = 1'b1;
                done_d  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Step register and latched request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= 1'b0;
            gate_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                sel_q  <= req_idx;
                gate_q <= req_gate;
            end
        end
    end

    // Registered status: pulses and the sticky timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            err_illegal <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            done        <= done_d;
            err_illegal <= ill_d;
            if (tmo_clr)
                err_timeout <= 1'b0;
            else if (tmo_set)
                err_timeout <= 1'b1;
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign in_settle = (state_q == ST_SETTLE);

endmodule

// File: rtl/domain_power_sequencer.sv
// Top: sequences shutdown and restart of a master and a slave clock domain
// around a single-transaction register crossing. Assumes xing_busy is
// synchronous to clk. Never controls power, only clocks, resets and bypass.
module domain_power_sequencer
    import dps_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_dom,
    input  logic             req_on,
    input  logic             req_gate,
    input  logic             abort,
    input  logic [CNT_W-1:0] cfg_settle,
    input  logic [CNT_W-1:0] cfg_timeout,
    input  logic             xing_busy,
    output logic             mst_clk_en,
    output logic             mst_reset,
    output logic             slv_clk_en,
    output logic             slv_reset,
    output logic             slv_bypass,
    output logic             busy,
    output logic             done,
    output logic             err_illegal,
    output logic             err_timeout
);
    dom_cmd_t [DOM_COUNT-1:0] cmd;
    logic [DOM_COUNT-1:0]     clk_en_w, rst_w, byp_w;
    logic                     cnt_clr, cnt_inc, cnt_hit, in_settle;
    logic [CNT_W-1:0]         cnt_limit;

    // One output register set per controlled domain.
    for (genvar g = 0; g < DOM_COUNT; g++) begin : g_dom
        dps_domain u_dom (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd[g]),
            .clk_en    (clk_en_w[g]),
            .dom_reset (rst_w[g]),
            .bypass    (byp_w[g])
        );
    end

    dps_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_dom     (req_dom),
        .req_on      (req_on),
        .req_gate    (req_gate),
        .abort       (abort),
        .xing_busy   (xing_busy),
        .cnt_hit     (cnt_hit),
        .dom_off     (rst_w),
        .dom_byp     (byp_w),
        .cmd         (cmd),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc),
        .in_settle   (in_settle),
        .busy        (busy),
        .done        (done),
        .err_illegal (err_illegal),
        .err_timeout (err_timeout)
    );

    // The settle and drain waits never overlap, so one counter serves both.
    assign cnt_limit = in_settle ? cfg_settle : cfg_timeout;

    dps_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .limit (cnt_limit),
        .hit   (cnt_hit)
    );

    assign mst_clk_en = clk_en_w[DOM_MST];
    assign mst_reset  = rst_w[DOM_MST];
    assign slv_clk_en = clk_en_w[DOM_SLV];
    assign slv_reset  = rst_w[DOM_SLV];
    assign slv_bypass = byp_w[DOM_SLV];

endmodule

// File: rtl/dps_checker.sv
// Ordering and safety properties of the sequencer, observed at its ports.
module dps_checker (
    input logic clk,
    input logic rst_n,
    input logic xing_busy,
    input logic abort,
    input logic mst_clk_en,
    input logic mst_reset,
    input logic slv_clk_en,
    input logic slv_reset,
    input logic slv_bypass,
    input logic done,
    input logic err_illegal,
    input logic err_timeout
);
    assert_slv_reset_needs_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slv_reset |-> slv_bypass);

    assert_bypass_drop_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slv_bypass) |-> (!slv_reset && slv_clk_en));

    assert_mst_reset_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_reset) |-> !$past(xing_busy));

    assert_slv_reset_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slv_reset) |-> !$past(xing_busy));

    assert_mst_clock_stop_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mst_clk_en) |-> mst_reset);

    assert_slv_clock_stop_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slv_clk_en) |-> slv_reset);

    assert_mst_release_clocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mst_reset) |-> (mst_clk_en && $past(mst_clk_en)));

    assert_slv_release_clocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slv_reset) |-> (slv_clk_en && $past(slv_clk_en)));

    assert_done_or_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_illegal}));

    assert_timeout_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_timeout) |-> $past(abort));

endmodule

bind domain_power_sequencer dps_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xing_busy   (xing_busy),
    .abort       (abort),
    .mst_clk_en  (mst_clk_en),
    .mst_reset   (mst_reset),
    .slv_clk_en  (slv_clk_en),
    .slv_reset   (slv_reset),
    .slv_bypass  (slv_bypass),
    .done        (done),
    .err_illegal (err_illegal),
    .err_timeout (err_timeout)
);

// File: tb/domain_power_sequencer_test.sv
`timescale 1ns/1ps
module domain_power_sequencer_test;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_dom = '0;
    logic             req_on = 1'b0;
    logic             req_gate = 1'b0;
    logic             abort = 1'b0;
    logic [CNT_W-1:0] cfg_settle = 8'd4;
    logic [CNT_W-1:0] cfg_timeout = 8'd50;
    logic             xing_busy = 1'b0;
    logic mst_clk_en, mst_reset, slv_clk_en, slv_reset, slv_bypass;
    logic busy, done, err_illegal, err_timeout;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    domain_power_sequencer #(.CNT_W(CNT_W)) uut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Domain output readers (0 master, 1 slave).
    function automatic int rst_of(input int d);
        return (d == 1) ? int'(slv_reset) : int'(mst_reset);
    endfunction
    function automatic int clk_of(input int d);
        return (d == 1) ? int'(slv_clk_en) : int'(mst_clk_en);
    endfunction

    // Present a request for one edge; returns at the negedge after acceptance.
    task automatic issue(input int d, input int on, input int gate);
        req_dom   = 2'(d);
        req_on    = 1'(on);
        req_gate  = 1'(gate);
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
    endtask

    // Off sequence with xing_busy held for b wait edges.
    task automatic run_off(input int d, input int gate, input int b);
        xing_busy = (b > 0);
        issue(d, 0, gate);
        chk("R2 bypass raised at accept", slv_bypass, d);
        chk("R2 reset still low at accept", rst_of(d), 0);
        chk("R4 busy during sequence", busy, 1);
        for (int i = 1; i <= b; i++) begin
            chk("R3 reset held while in flight", rst_of(d), 0);
            tick();
        end
        xing_busy = 1'b0;
        chk("R3 reset low before idle edge", rst_of(d), 0);
        tick();
        chk("R3 reset after idle edge", rst_of(d), 1);
        chk("R4 clock runs one edge past reset", clk_of(d), 1);
        chk("R4 no early done", done, 0);
        chk("R5 bypass only for slave", slv_bypass, d);
        tick();
        chk("R4 clock gate choice", clk_of(d), (gate != 0) ? 0 : 1);
        chk("R4 done pulse", done, 1);
        chk("R4 busy cleared", busy, 0);
        tick();
        chk("R4 done one cycle", done, 0);
    endtask

    // On sequence with settle s.
    task automatic run_on(input int d, input int s);
        int m;
        m = (s < 1) ? 1 : s;
        cfg_settle = 8'(s);
        issue(d, 1, 0);
        chk("R6 clock enabled at accept", clk_of(d), 1);
        chk("R6 reset held at accept", rst_of(d), 1);
        for (int i = 2; i <= m; i++) begin
            tick();
            chk("R6 reset held during settle", rst_of(d), 1);
        end
        tick();
        chk("R6 reset released after settle", rst_of(d), 0);
        chk("R6 bypass still held", slv_bypass, d);
        chk("R6 no early done", done, 0);
        tick();
        chk("R6 bypass released last", slv_bypass, 0);
        chk("R6 done pulse", done, 1);
        chk("R6 busy cleared", busy, 0);
        tick();
        chk("R6 done one cycle", done, 0);
    endtask

    task automatic chk_all_on(input string tag);
        chk(tag, {mst_clk_en, mst_reset, slv_clk_en, slv_reset, slv_bypass}, 5'b10100);
    endtask

    initial begin
        int settles[3] = '{0, 1, 3};
        int holds[3]   = '{0, 2, 3};
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: power-on state.
        chk_all_on("R1 domain outputs after reset");
        chk("R1 status after reset", {busy, done, err_illegal, err_timeout}, 0);

        // Sweep domain, gating, in-flight hold and settle length (R2-R6, R7).
        for (int d = 0; d < 2; d++)
            for (int g = 0; g < 2; g++)
                for (int h = 0; h < 3; h++)
                    for (int s = 0; s < 3; s++) begin
                        run_off(d, g, holds[h]);
                        run_on(d, settles[s]);
                        chk_all_on("R7 back to running");
                    end

        // R10: already on.
        issue(0, 1, 0);
        chk("R10 done on redundant on", done, 1);
        chk_all_on("R10 outputs unchanged");
        tick();
        chk("R10 done one cycle", done, 0);
        // R10: already off.
        run_off(1, 1, 0);
        issue(1, 0, 0);
        chk("R10 done on redundant off", done, 1);
        chk("R10 slave stays off", {slv_clk_en, slv_reset, slv_bypass}, 3'b011);
        chk("R10 not busy", busy, 0);
        tick();
        run_on(1, 2);

        // R8: illegal domain codes.
        for (int code = 2; code < 4; code++) begin
            issue(code, 0, 1);
            chk("R8 illegal pulse", err_illegal, 1);
            chk("R8 no done", done, 0);
            chk_all_on("R8 outputs unchanged");
            tick();
            chk("R8 pulse one cycle", err_illegal, 0);
            chk("R8 not busy", busy, 0);
        end

        // R9: request during a sequence is dropped.
        xing_busy = 1'b1;
        issue(0, 0, 1);
        issue(1, 0, 0);
        tick();
        chk("R9 slave bypass untouched", slv_bypass, 0);
        xing_busy = 1'b0;
        repeat (4) tick();
        chk("R9 master off only", {mst_clk_en, mst_reset, slv_bypass, slv_reset}, 4'b0100);
        run_on(0, 1);

        // R12: abort while idle has no effect.
        abort = 1'b1;
        tick();
        abort = 1'b0;
        chk_all_on("R12 idle abort ignored");
        chk("R12 idle abort no busy", busy, 0);

        // R11: timeout after 5 wait edges, sticky while busy clears.
        cfg_timeout = 8'd5;
        xing_busy = 1'b1;
        issue(1, 0, 1);
        for (int i = 1; i < 5; i++) tick();
        chk("R11 no timeout before limit", err_timeout, 0);
        tick();
        chk("R11 timeout at limit", err_timeout, 1);
        xing_busy = 1'b0;
        repeat (3) tick();
        chk("R11 timeout sticky", err_timeout, 1);
        chk("R11 reset withheld after timeout", slv_reset, 0);
        chk("R11 still busy", busy, 1);

        // R12: abort leaves the wait.
        abort = 1'b1;
        tick();
        abort = 1'b0;
        chk("R12 abort clears timeout", err_timeout, 0);
        chk("R12 abort to idle", busy, 0);
        chk("R12 abort no done", done, 0);
        chk_all_on("R12 bypass withdrawn");
        cfg_timeout = 8'd50;

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule